// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block sends one frame of serial words each time a frame-sync is seen. A frame is made of either one phase or two phases. Each phase has its own word count and its own word length. The length comes from a small code that selects 8, 12, 16, 20, 24 or 32 bits. Words arrive in parallel over a valid/ready handshake. Each word is taken from the low-order bits of a 32-bit input and shifted out most significant bit first, one bit for each clock on which the bit-clock enable is high.

The configuration is captured when the frame starts, so software may change it while a frame is running. The block reports three sticky error conditions: a reserved length code, a word slot that found no valid input word, and a frame-sync that arrived during a frame. It also gives one-clock pulses at the end of each word and at the end of the frame.

Top module: `dual_phase_frame_tx`

## Requirements
- R1: After reset, sdata_o, busy_o, word_done_o, frame_done_o, cfg_err_o, underflow_o and fsync_err_o are all 0, and word_ready_o is 0 while bit_en_i is 0.
- R2: When fsync_i and bit_en_i are both high at a clock edge while idle, word_ready_o is high in that cycle, busy_o is 1 after that edge, and sdata_o then carries the first bit of the first word.
- R3: The length code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits. A word of L bits is word_i[L-1:0], sent MSB first with one bit for each enabled clock.
- R4: With phase_mode_i=0, a frame holds p1_words_i+1 words, all of the phase-1 length.
- R5: With phase_mode_i=1, p1_words_i+1 words of the phase-1 length are followed by p2_words_i+1 words of the phase-2 length.
- R6: The codes 6 and 7 are sent as 8-bit words and set the sticky cfg_err_o. The phase-2 code is examined only in dual-phase mode.
- R7: A word slot that starts while word_valid_i is 0 sends zeros, consumes no input word, and sets the sticky underflow_o.
- R8: A frame-sync sampled during a frame does not disturb the frame and sets the sticky fsync_err_o.
- R9: Changes to the configuration inputs after the starting edge do not affect the frame in progress.
- R10: word_done_o is high for one clock after each word ends. frame_done_o is high for one clock, together with the last word_done_o. busy_o drops at the same edge.
- R11: While bit_en_i is 0, sdata_o and busy_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable: one serial bit per high cycle |
| fsync_i | input | 1 | Frame-sync, sampled only when bit_en_i is high |
| phase_mode_i | input | 1 | 0: single-phase frame, 1: dual-phase frame |
| p1_words_i | input | 7 | Phase-1 word count minus one |
| p1_len_i | input | 3 | Phase-1 word-length code |
| p2_words_i | input | 7 | Phase-2 word count minus one |
| p2_len_i | input | 3 | Phase-2 word-length code |
| word_i | input | 32 | Parallel word; the low-order bits are sent |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | A word slot starts in this cycle |
| sdata_o | output | 1 | Serial data bit |
| busy_o | output | 1 | A frame is in progress |
| word_done_o | output | 1 | One-clock pulse at the end of each word |
| frame_done_o | output | 1 | One-clock pulse at the end of the frame |
| cfg_err_o | output | 1 | Sticky: a reserved length code was used |
| underflow_o | output | 1 | Sticky: a word slot had no valid input word |
| fsync_err_o | output | 1 | Sticky: a frame-sync arrived during a frame |

## Verification
Every result is registered. The first bit appears on sdata_o directly after the enabled edge that samples frame-sync, and each further bit appears after the next enabled edge. word_done_o, frame_done_o and the falling busy_o appear after the enabled edge that ends the last bit. The sticky flags rise after the edge that detects their cause. The bench drives inputs at falling edges, reads word_ready_o just before the rising edge, and samples every output 1 ns after each rising edge. Between enabled edges it confirms that sdata_o has not moved.

// File: rtl/dpft_pkg.sv
`timescale 1ns/1ps
package dpft_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Bit count selected by a length code; 0 marks a reserved code.
    function automatic int code_len(input int code);
        case (code)
            0:       return 8;
            1:       return 12;
            2:       return 16;
            3:       return 20;
            4:       return 24;
            5:       return 32;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dpft_len_decode.sv
`timescale 1ns/1ps
module dpft_len_decode #(
    parameter int CODE_W = 3,
    parameter int BITS_W = 6
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [BITS_W-1:0] bits_o,
    output logic              reserved_o
);
    int len;

    always_comb begin
        len        = dpft_pkg::code_len(int'(code_i));
        reserved_o = (len == 0);
        bits_o     = reserved_o ? BITS_W'(8) : BITS_W'(len);
    end

endmodule

// File: rtl/dpft_word_align.sv
`timescale 1ns/1ps
module dpft_word_align #(
    parameter int WORD_W = 32,
    parameter int BITS_W = 6
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    input  logic [BITS_W-1:0] bits_i,
    output logic [WORD_W-1:0] aligned_o
);
    logic [BITS_W-1:0] pad;

    // Move the low-order word bits up to the MSB end of the shifter.
    always_comb begin
        pad       = BITS_W'(WORD_W) - bits_i;
        aligned_o = valid_i ? (word_i << pad) : '0;
    end

endmodule

// File: rtl/dual_phase_frame_tx.sv
`timescale 1ns/1ps
module dual_phase_frame_tx #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 7,
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_en_i,
    input  logic              fsync_i,
    input  logic              phase_mode_i,
    input  logic [CNT_W-1:0]  p1_words_i,
    input  logic [CODE_W-1:0] p1_len_i,
    input  logic [CNT_W-1:0]  p2_words_i,
    input  logic [CODE_W-1:0] p2_len_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    output logic              sdata_o,
    output logic              busy_o,
    output logic              word_done_o,
    output logic              frame_done_o,
    output logic              cfg_err_o,
    output logic              underflow_o,
    output logic              fsync_err_o
);
    import dpft_pkg::*;

    localparam int BITS_W = $clog2(WORD_W + 1);
    localparam int NPH    = 2;

    typedef struct packed {
        logic              busy;
        phase_e            phase;
        logic              dual;
        logic [CNT_W-1:0]  cnt2;
        logic [BITS_W-1:0] len1b;
        logic [BITS_W-1:0] len2b;
        logic [CNT_W-1:0]  words_left;
        logic [BITS_W-1:0] bits_left;
        logic [WORD_W-1:0] shreg;
        logic              word_done;
        logic              frame_done;
        logic              cfg_err;
        logic              underflow;
        logic              fsync_err;
    } state_t;

    state_t st_q, st_d;

    // Length decoders, one per phase.
    logic [CODE_W-1:0] code_in  [NPH];
    logic [BITS_W-1:0] dec_bits [NPH];
    logic              dec_res  [NPH];

    assign code_in[0] = p1_len_i;
    assign code_in[1] = p2_len_i;

    for (genvar g = 0; g < NPH; g++) begin : g_dec
        dpft_len_decode #(
            .CODE_W(CODE_W),
            .BITS_W(BITS_W)
        ) u_dec (
            .code_i    (code_in[g]),
            .bits_o    (dec_bits[g]),
            .reserved_o(dec_res[g])
        );
    end

    logic              start_d;
    logic              word_end_d;
    logic              more_same_d;
    logic              to_ph2_d;
    logic              load_d;
    logic [BITS_W-1:0] cur_len_d;
    logic [BITS_W-1:0] load_len_d;
    logic [WORD_W-1:0] aligned_d;

    dpft_word_align #(
        .WORD_W(WORD_W),
        .BITS_W(BITS_W)
    ) u_align (
        .word_i   (word_i),
        .valid_i  (word_valid_i),
        .bits_i   (load_len_d),
        .aligned_o(aligned_d)
    );

    always_comb begin
        cur_len_d   = (st_q.phase == PH_SECOND) ? st_q.len2b : st_q.len1b;
        start_d     = bit_en_i && fsync_i && !st_q.busy;
        word_end_d  = bit_en_i && st_q.busy && (st_q.bits_left == BITS_W'(1));
        more_same_d = (st_q.words_left != '0);
        to_ph2_d    = (st_q.phase == PH_FIRST) && st_q.dual;
        load_d      = start_d || (word_end_d && (more_same_d || to_ph2_d));
        if (!st_q.busy)       load_len_d = dec_bits[0];
        else if (more_same_d) load_len_d = cur_len_d;
        else                  load_len_d = st_q.len2b;

        st_d            = st_q;
        st_d.word_done  = 1'b0;
        st_d.frame_done = 1'b0;

        if (start_d) begin
            st_d.busy       = 1'b1;
            st_d.phase      = PH_FIRST;
            st_d.dual       = phase_mode_i;
            st_d.cnt2       = p2_words_i;
            st_d.len1b      = dec_bits[0];
            st_d.len2b      = dec_bits[1];
            st_d.words_left = p1_words_i;
            st_d.bits_left  = dec_bits[0];
            st_d.shreg      = aligned_d;
            st_d.cfg_err    = st_q.cfg_err | dec_res[0] | (phase_mode_i & dec_res[1]);
            st_d.underflow  = st_q.underflow | ~word_valid_i;
        end else if (bit_en_i && st_q.busy) begin
            if (fsync_i) begin
                st_d.fsync_err = 1'b1;
            end
            if (!word_end_d) begin
                st_d.shreg     = st_q.shreg << 1;
                st_d.bits_left = st_q.bits_left - BITS_W'(1);
            end else begin
                st_d.word_done = 1'b1;
                if (more_same_d) begin
                    st_d.words_left = st_q.words_left - CNT_W'(1);
                    st_d.bits_left  = cur_len_d;
                    st_d.shreg      = aligned_d;
                    st_d.underflow  = st_q.underflow | ~word_valid_i;
                end else if (to_ph2_d) begin
                    st_d.phase      = PH_SECOND;
                    st_d.words_left = st_q.cnt2;
                    st_d.bits_left  = st_q.len2b;
                    st_d.shreg      = aligned_d;
                    st_d.underflow  = st_q.underflow | ~word_valid_i;
                end else begin
                    st_d.busy       = 1'b0;
                    st_d.frame_done = 1'b1;
                    st_d.bits_left  = '0;
                    st_d.shreg      = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign word_ready_o = load_d;
    assign sdata_o      = st_q.shreg[WORD_W-1];
    assign busy_o       = st_q.busy;
    assign word_done_o  = st_q.word_done;
    assign frame_done_o = st_q.frame_done;
    assign cfg_err_o    = st_q.cfg_err;
    assign underflow_o  = st_q.underflow;
    assign fsync_err_o  = st_q.fsync_err;

    AST_FRAME_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !frame_done_o); // R10
    AST_FRAME_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> (word_done_o && !busy_o)); // R10
    AST_HOLD_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> ($stable(sdata_o) && $stable(busy_o))); // R11
    AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !sdata_o); // R1
    AST_START_TAKES_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && fsync_i && !busy_o) |-> word_ready_o); // R2
    AST_CFG_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o); // R6
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_o |=> underflow_o); // R7
    AST_FSYNC_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_err_o |=> fsync_err_o); // R8
    AST_MIDFRAME_FSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && bit_en_i && fsync_i) |=> fsync_err_o); // R8

endmodule

// File: tb/dual_phase_frame_tx_tb_top.sv
`timescale 1ns/1ps
module dual_phase_frame_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b0;
    logic        mode = 1'b0;
    logic [6:0]  c1 = '0, c2 = '0;
    logic [2:0]  l1 = '0, l2 = '0;
    logic [31:0] word = '0;
    logic        valid = 1'b0;
    logic        ready, sdata, busy, wdone, fdone, cerr, uflow, ferr;

    always #2.5 clk = ~clk;

    dual_phase_frame_tx dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .fsync_i(fsync),
        .phase_mode_i(mode), .p1_words_i(c1), .p1_len_i(l1),
        .p2_words_i(c2), .p2_len_i(l2), .word_i(word), .word_valid_i(valid),
        .word_ready_o(ready), .sdata_o(sdata), .busy_o(busy),
        .word_done_o(wdone), .frame_done_o(fdone), .cfg_err_o(cerr),
        .underflow_o(uflow), .fsync_err_o(ferr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Fields: mode[36] c1[35:29] l1[28:26] c2[25:19] l2[18:16] div[15:12] bits[11:0]
    localparam logic [36:0] VEC [6] = '{
        {1'b0, 7'd0, 3'd0, 7'd0, 3'd0, 4'd1, 12'd8},
        {1'b0, 7'd3, 3'd5, 7'd0, 3'd0, 4'd1, 12'd128},
        {1'b1, 7'd1, 3'd1, 7'd2, 3'd4, 4'd2, 12'd96},
        {1'b1, 7'd0, 3'd2, 7'd0, 3'd3, 4'd3, 12'd36},
        {1'b0, 7'd2, 3'd4, 7'd5, 3'd1, 4'd1, 12'd72},
        {1'b1, 7'd2, 3'd5, 7'd1, 3'd0, 4'd1, 12'd112}
    };

    bit cap [4096];
    bit expb [4096];
    int ncap, nexp, nwd, nfd, unstable;
    bit first_ready, first_busy;

    function automatic int blen(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            3'd5: return 32;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] pat(input int k);
        return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bit_en = 1'b0;
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic build_exp(input logic m, input logic [6:0] a1, input logic [2:0] b1,
                             input logic [6:0] a2, input logic [2:0] b2, input int starve);
        int slot = 0;
        int widx = 0;
        nexp = 0;
        for (int ph = 0; ph < (m ? 2 : 1); ph++) begin
            int n = (ph == 0) ? int'(a1) + 1 : int'(a2) + 1;
            int len = blen(ph == 0 ? b1 : b2);
            for (int w = 0; w < n; w++) begin
                logic [31:0] v;
                if (slot == starve) v = '0;
                else begin
                    v = pat(widx);
                    widx++;
                end
                for (int b = len - 1; b >= 0; b--) begin
                    expb[nexp] = v[b];
                    nexp++;
                end
                slot++;
            end
        end
    endtask

    task automatic run_frame(input logic m, input logic [6:0] a1, input logic [2:0] b1,
                             input logic [6:0] a2, input logic [2:0] b2, input int div,
                             input int starve, input int xfs, input bit scramble);
        int cyc = 0;
        int slot = 0;
        int widx = 0;
        bit prev = 1'b0;
        bit took;
        ncap = 0; nwd = 0; nfd = 0; unstable = 0;
        mode = m; c1 = a1; l1 = b1; c2 = a2; l2 = b2;
        while (nfd == 0 && cyc < 20000) begin
            @(negedge clk);
            bit_en = (cyc % div) == 0;
            fsync  = bit_en && ((cyc == 0) || (xfs >= 0 && ncap == xfs && busy));
            valid  = (slot != starve);
            word   = pat(widx);
            if (scramble && cyc > 0) begin
                mode = ~m; c1 = ~a1; l1 = b1 + 3'd1; c2 = ~a2; l2 = b2 + 3'd2;
            end
            #0.5;
            took = bit_en && ready;
            if (cyc == 0) first_ready = ready;
            @(posedge clk);
            #1;
            if (took) begin
                if (valid) widx++;
                slot++;
            end
            if (cyc == 0) first_busy = busy;
            if (bit_en) begin
                if (busy) begin
                    cap[ncap] = sdata;
                    ncap++;
                end
                if (wdone) nwd++;
                if (fdone) nfd++;
            end else if (sdata != prev) begin
                unstable++;
            end
            prev = sdata;
            cyc++;
        end
        @(negedge clk);
        bit_en = 1'b0;
        fsync = 1'b0;
        mode = m; c1 = a1; l1 = b1; c2 = a2; l2 = b2;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        int bad = -1;
        chk(ncap == nexp, req, "bit count", ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++)
            if (bad < 0 && cap[i] != expb[i]) bad = i;
        chk(bad < 0, req, "first mismatching bit index", bad, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk({sdata, busy, wdone, fdone, cerr, uflow, ferr} == 7'b0, "R1",
            "outputs after reset", int'({sdata, busy, wdone, fdone, cerr, uflow, ferr}), 0);
        chk(ready == 1'b0, "R1", "ready while idle without enable", int'(ready), 0);

        // Table of frame configurations (R3, R4, R5, R10, R11)
        foreach (VEC[i]) begin
            logic [36:0] v = VEC[i];
            int nw = int'(v[35:29]) + 1 + (v[36] ? int'(v[25:19]) + 1 : 0);
            build_exp(v[36], v[35:29], v[28:26], v[25:19], v[18:16], -1);
            chk(nexp == int'(v[11:0]), "R3", "table length vs code map", nexp, int'(v[11:0]));
            run_frame(v[36], v[35:29], v[28:26], v[25:19], v[18:16], int'(v[15:12]), -1, -1, 1'b0);
            check_stream(v[36] ? "R5" : "R4");
            chk(nwd == nw, "R10", "word_done pulses", nwd, nw);
            chk(nfd == 1, "R10", "frame_done pulses", nfd, 1);
            chk(unstable == 0, "R11", "sdata moves without enable", unstable, 0);
            if (i == 0) begin
                chk(first_ready == 1'b1, "R2", "ready at start edge", int'(first_ready), 1);
                chk(first_busy == 1'b1, "R2", "busy after start edge", int'(first_busy), 1);
            end
        end
        chk({cerr, uflow, ferr} == 3'b0, "R7", "no sticky flags from clean frames",
            int'({cerr, uflow, ferr}), 0);
        chk(busy == 1'b0 && sdata == 1'b0, "R10", "idle after frames", int'({busy, sdata}), 0);

        // R6: reserved code 6 on phase 1 is sent as 8-bit words
        do_reset();
        build_exp(1'b0, 7'd1, 3'd6, 7'd0, 3'd0, -1);
        run_frame(1'b0, 7'd1, 3'd6, 7'd0, 3'd0, 1, -1, -1, 1'b0);
        check_stream("R6");
        chk(cerr == 1'b1, "R6", "cfg_err after reserved code", int'(cerr), 1);

        // R6: reserved phase-2 code is ignored in single-phase mode
        do_reset();
        run_frame(1'b0, 7'd0, 3'd1, 7'd0, 3'd7, 1, -1, -1, 1'b0);
        chk(cerr == 1'b0, "R6", "cfg_err with unused phase-2 code", int'(cerr), 0);

        // R7: starved slot 1 sends zeros, input word kept for slot 2
        do_reset();
        build_exp(1'b0, 7'd2, 3'd2, 7'd0, 3'd0, 1);
        run_frame(1'b0, 7'd2, 3'd2, 7'd0, 3'd0, 1, 1, -1, 1'b0);
        check_stream("R7");
        chk(uflow == 1'b1, "R7", "underflow after starved slot", int'(uflow), 1);

        // R8: frame-sync in the middle of a frame
        do_reset();
        build_exp(1'b1, 7'd1, 3'd1, 7'd0, 3'd0, -1);
        run_frame(1'b1, 7'd1, 3'd1, 7'd0, 3'd0, 2, -1, 5, 1'b0);
        check_stream("R8");
        chk(nfd == 1, "R8", "frame_done pulses with extra fsync", nfd, 1);
        chk(ferr == 1'b1, "R8", "fsync_err after mid-frame sync", int'(ferr), 1);

        // R9: configuration changed after the start edge
        do_reset();
        build_exp(1'b1, 7'd1, 3'd0, 7'd1, 3'd2, -1);
        run_frame(1'b1, 7'd1, 3'd0, 7'd1, 3'd2, 1, -1, -1, 1'b1);
        check_stream("R9");
        chk(nwd == 4, "R9", "word count with config changed", nwd, 4);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule